// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block decides, for a single repeater port, whether that port is isolated from the repeater core. One copy is placed per port, so every port partitions and reconnects on its own. Work happens on bit-time ticks. The block watches three activity lines of the port: receive, collision/SQE and transmit.

The port is isolated when either of two things happens. The first is a collision indication that lasts too long. The second is a run of transmit attempts that all collide. While isolated, the port still gets repeated traffic. Its own receive activity, however, is masked from the repeater core. The port is connected again once a clean, long packet has been seen. In the standard rule that packet may go in either direction. In the alternate rule it must be a transmit to the port.

The two outputs are a registered partitioned flag and a registered, gated receive-valid signal.

Top module: `apc_port_partition`

## Requirements
- R1: After reset the port is connected (`partitioned` = 0), `rx_valid` is 0 and the standard reconnection rule is in force.
- R2: If `col_act` is high on more than SQE_LIMIT consecutive ticks, the port partitions on the clock edge of tick SQE_LIMIT+1. Exactly SQE_LIMIT such ticks do not partition it.
- R3: A transmit attempt is one stretch of ticks with `tx_act` high. It ends on the first tick with `tx_act` low. If it saw `col_act` on any of its ticks, it counts as collided. The port partitions on the end tick of COL_LIMIT consecutive collided attempts.
- R4: An attempt that ends without any collision clears the collided-attempt run.
- R5: Under the standard rule, a partitioned port reconnects on the end tick of a receive stretch or a transmit stretch. That stretch must be longer than CLEAN_LEN ticks and must have no collision.
- R6: A receive or transmit stretch with `col_act` high on any tick never reconnects the port.
- R7: A stretch of exactly CLEAN_LEN ticks does not reconnect the port.
- R8: Under the alternate rule (`alt_mode` = 1 latched), only a clean transmit stretch longer than CLEAN_LEN ticks reconnects. Receive stretches do not.
- R9: `alt_mode` is latched only on clock edges where `rx_act`, `tx_act` and `col_act` are all low. A change made during activity takes effect only after the port goes idle.
- R10: `rx_valid` equals `rx_act` delayed one clock. It is forced to 0 while the port is partitioned or disabled.
- R11: While `port_en` is low, the port is held connected, `rx_valid` is 0, no trigger acts, and the collision counters are cleared.
- R12: Counting and stretch boundaries advance only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per bit time |
| port_en | input | 1 | Port enabled |
| alt_mode | input | 1 | 1 = transmit-only reconnection rule |
| rx_act | input | 1 | Receive activity on the port |
| col_act | input | 1 | Collision / SQE activity on the port |
| tx_act | input | 1 | Repeater transmitting to the port |
| partitioned | output | 1 | Port is isolated |
| rx_valid | output | 1 | Gated receive activity toward the repeater core |

## Verification
The bench builds the block with SQE_LIMIT = 16, COL_LIMIT = 4 and CLEAN_LEN = 8, and holds `tick` high on every clock except in the tick-gating test. With these values, every threshold can be reached exactly and missed by one in a few dozen clocks. Each threshold is driven on both sides of its boundary. The mode latch is exercised by changing `alt_mode` in the middle of a packet.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic {
    APC_LINKED   = 1'b0,
    APC_ISOLATED = 1'b1
  } apc_state_e;
endpackage

// File: rtl/apc_sqe_timer.sv
module apc_sqe_timer #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic col_act,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] MAXV = W'(LIMIT);

  logic [W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
    end else if (tick) begin
      if (!col_act)           run_q <= '0;
      else if (run_q != MAXV) run_q <= run_q + 1'b1;
    end
  end

  // the tick that would take the run past LIMIT
  assign expired = !clr && tick && col_act && (run_q == MAXV);
endmodule

// File: rtl/apc_strike_counter.sv
module apc_strike_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic tx_act,
  input  logic col_act,
  output logic tripped
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LASTV = W'(LIMIT - 1);

  logic [W-1:0] strikes_q;
  logic         tx_prev_q;
  logic         hit_q;
  logic         ends;

  assign ends = tick && !tx_act && tx_prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      strikes_q <= '0;
      tx_prev_q <= 1'b0;
      hit_q     <= 1'b0;
    end else if (tick) begin
      tx_prev_q <= tx_act;
      if (tx_act) begin
        if (col_act) hit_q <= 1'b1;
      end else if (tx_prev_q) begin
        hit_q <= 1'b0;
        if (!hit_q)                strikes_q <= '0;
        else if (strikes_q != LASTV) strikes_q <= strikes_q + 1'b1;
      end
    end
  end

  assign tripped = !clr && ends && hit_q && (strikes_q == LASTV);
endmodule

// File: rtl/apc_clean_len.sv
module apc_clean_len #(
  parameter int MIN_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic act,
  input  logic col_act,
  output logic clean
);
  localparam int W = $clog2(MIN_LEN + 2);
  localparam logic [W-1:0] LONGV = W'(MIN_LEN + 1);

  logic [W-1:0] len_q;
  logic         prev_q;
  logic         dirty_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len_q   <= '0;
      prev_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else if (tick) begin
      prev_q <= act;
      if (act) begin
        if (len_q != LONGV) len_q <= len_q + 1'b1;
        if (col_act)        dirty_q <= 1'b1;
      end else begin
        len_q   <= '0;
        dirty_q <= 1'b0;
      end
    end
  end

  assign clean = !clr && tick && !act && prev_q && !dirty_q && (len_q == LONGV);
endmodule

// File: rtl/apc_port_partition.sv
module apc_port_partition #(
  parameter int SQE_LIMIT = 2048,
  parameter int COL_LIMIT = 32,
  parameter int CLEAN_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic port_en,
  input  logic alt_mode,
  input  logic rx_act,
  input  logic col_act,
  input  logic tx_act,
  output logic partitioned,
  output logic rx_valid
);
  import apc_pkg::*;

  localparam int DIRS = 2;  // index 0 receive, 1 transmit

  apc_state_e state_q;
  logic       mode_q;
  logic       rx_valid_q;
  logic       trig_sqe;
  logic       trig_strike;
  logic       cnt_clr;
  logic       idle;
  logic [DIRS-1:0] dir_act;
  logic [DIRS-1:0] dir_clean;
  logic       rejoin;

  assign cnt_clr = !port_en || (state_q == APC_ISOLATED);
  assign idle    = !rx_act && !tx_act && !col_act;
  assign dir_act = {tx_act, rx_act};

  apc_sqe_timer #(.LIMIT(SQE_LIMIT)) u_sqe (
    .clk(clk), .rst(rst), .clr(cnt_clr), .tick(tick),
    .col_act(col_act), .expired(trig_sqe)
  );

  apc_strike_counter #(.LIMIT(COL_LIMIT)) u_strike (
    .clk(clk), .rst(rst), .clr(cnt_clr), .tick(tick),
    .tx_act(tx_act), .col_act(col_act), .tripped(trig_strike)
  );

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    apc_clean_len #(.MIN_LEN(CLEAN_LEN)) u_len (
      .clk(clk), .rst(rst), .clr(!port_en), .tick(tick),
      .act(dir_act[d]), .col_act(col_act), .clean(dir_clean[d])
    );
  end

  assign rejoin = dir_clean[1] || (!mode_q && dir_clean[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
    end else if (idle) begin
      mode_q <= alt_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      state_q <= APC_LINKED;
    end else begin
      unique case (state_q)
        APC_LINKED:   if (trig_sqe || trig_strike) state_q <= APC_ISOLATED;
        APC_ISOLATED: if (rejoin)                  state_q <= APC_LINKED;
        default:      state_q <= APC_LINKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_valid_q <= 1'b0;
    else     rx_valid_q <= rx_act && port_en && (state_q == APC_LINKED);
  end

  assign partitioned = (state_q == APC_ISOLATED);
  assign rx_valid    = rx_valid_q;
endmodule

// File: rtl/apc_port_partition_chk.sv
module apc_port_partition_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic port_en,
  input logic rx_act,
  input logic partitioned,
  input logic rx_valid
);
  // R11
  disabled_holds_linked_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !partitioned);

  // R10
  rx_valid_gated_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(rx_act) && $past(port_en) && !$past(partitioned)));

  // R12
  isolate_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(partitioned) |-> ($past(tick) && $past(port_en)));

  // R5
  rejoin_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(partitioned) && $past(port_en)) |-> $past(tick));
endmodule

bind apc_port_partition apc_port_partition_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .port_en(port_en), .rx_act(rx_act),
  .partitioned(partitioned), .rx_valid(rx_valid)
);

// File: tb/apc_port_partition_test.sv
module apc_port_partition_test;
  localparam int SQE_L = 16;
  localparam int COL_L = 4;
  localparam int LEN_L = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, port_en = 1'b1, alt_mode = 1'b0;
  logic rx_act = 1'b0, col_act = 1'b0, tx_act = 1'b0;
  logic partitioned, rx_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  apc_port_partition #(.SQE_LIMIT(SQE_L), .COL_LIMIT(COL_L), .CLEAN_LEN(LEN_L)) uut (
    .clk(clk), .rst(rst), .tick(tick), .port_en(port_en), .alt_mode(alt_mode),
    .rx_act(rx_act), .col_act(col_act), .tx_act(tx_act),
    .partitioned(partitioned), .rx_valid(rx_valid)
  );

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b1; port_en = 1'b1; alt_mode = 1'b0;
    rx_act = 1'b0; col_act = 1'b0; tx_act = 1'b0;
    run(2);
    rst = 1'b0;
    run(1);
  endtask

  task automatic sqe_burst(input int n);
    col_act = 1'b1; run(n); col_act = 1'b0; run(1);
  endtask

  task automatic attempt(input logic col);
    tx_act = 1'b1; col_act = col; run(3);
    tx_act = 1'b0; col_act = 1'b0; run(2);
  endtask

  task automatic stretch(input bit is_tx, input int n, input bit dirty);
    if (is_tx) tx_act = 1'b1; else rx_act = 1'b1;
    col_act = dirty; run(1); col_act = 1'b0;
    run(n - 1);
    tx_act = 1'b0; rx_act = 1'b0; run(2);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 partitioned after reset", partitioned, 1'b0);
    check("R1 rx_valid after reset", rx_valid, 1'b0);
  endtask

  task automatic t_sqe();
    do_reset(); sqe_burst(SQE_L);
    check("R2 at limit", partitioned, 1'b0);
    do_reset(); sqe_burst(SQE_L + 1);
    check("R2 past limit", partitioned, 1'b1);
  endtask

  task automatic t_strikes();
    do_reset();
    for (int i = 0; i < COL_L - 1; i++) attempt(1'b1);
    check("R3 one short", partitioned, 1'b0);
    attempt(1'b1);
    check("R3 at limit", partitioned, 1'b1);
  endtask

  task automatic t_strike_clear();
    do_reset();
    for (int i = 0; i < COL_L - 1; i++) attempt(1'b1);
    attempt(1'b0);
    for (int i = 0; i < COL_L - 1; i++) attempt(1'b1);
    check("R4 run cleared", partitioned, 1'b0);
  endtask

  task automatic t_standard();
    do_reset(); sqe_burst(SQE_L + 1);
    stretch(1'b0, LEN_L, 1'b0);
    check("R7 exact length rx", partitioned, 1'b1);
    stretch(1'b0, LEN_L + 4, 1'b1);
    check("R6 dirty rx", partitioned, 1'b1);
    stretch(1'b0, LEN_L + 1, 1'b0);
    check("R5 clean rx", partitioned, 1'b0);
    sqe_burst(SQE_L + 1);
    stretch(1'b1, LEN_L + 4, 1'b1);
    check("R6 dirty tx", partitioned, 1'b1);
    stretch(1'b1, LEN_L + 1, 1'b0);
    check("R5 clean tx", partitioned, 1'b0);
  endtask

  task automatic t_alt();
    do_reset(); alt_mode = 1'b1; run(1);
    sqe_burst(SQE_L + 1);
    stretch(1'b0, LEN_L + 4, 1'b0);
    check("R8 rx ignored", partitioned, 1'b1);
    stretch(1'b1, LEN_L + 4, 1'b0);
    check("R8 tx rejoins", partitioned, 1'b0);
  endtask

  task automatic t_mode_latch();
    do_reset(); sqe_burst(SQE_L + 1);
    rx_act = 1'b1; run(2);
    alt_mode = 1'b1; run(LEN_L + 2);
    rx_act = 1'b0; run(2);
    check("R9 mode held during packet", partitioned, 1'b0);
    sqe_burst(SQE_L + 1);
    stretch(1'b0, LEN_L + 4, 1'b0);
    check("R9 mode taken when idle", partitioned, 1'b1);
  endtask

  task automatic t_gate();
    do_reset();
    rx_act = 1'b1; run(1);
    check("R10 connected rx", rx_valid, 1'b1);
    rx_act = 1'b0; run(1);
    check("R10 rx drop", rx_valid, 1'b0);
    sqe_burst(SQE_L + 1);
    rx_act = 1'b1; run(1);
    check("R10 partitioned rx", rx_valid, 1'b0);
    rx_act = 1'b0; run(1);
  endtask

  task automatic t_disable();
    do_reset(); port_en = 1'b0;
    sqe_burst(SQE_L + 4);
    check("R11 disabled no trigger", partitioned, 1'b0);
    rx_act = 1'b1; run(1);
    check("R11 disabled rx_valid", rx_valid, 1'b0);
    rx_act = 1'b0; port_en = 1'b1; run(1);
    sqe_burst(SQE_L + 1);
    port_en = 1'b0; run(1);
    check("R11 disable releases", partitioned, 1'b0);
    port_en = 1'b1; run(1);
    for (int i = 0; i < COL_L - 1; i++) attempt(1'b1);
    port_en = 1'b0; run(1); port_en = 1'b1; run(1);
    attempt(1'b1);
    check("R11 counters cleared", partitioned, 1'b0);
  endtask

  task automatic t_tick();
    do_reset(); tick = 1'b0;
    sqe_burst(SQE_L * 2);
    check("R12 no tick no count", partitioned, 1'b0);
    tick = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sqe();
    t_strikes();
    t_strike_clear();
    t_standard();
    t_alt();
    t_mode_latch();
    t_gate();
    t_disable();
    t_tick();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule